// File: doc/BRIEF.md
# Dual-Standard Composite Sync Generator

This block times a character-mapped video display from a 6.5 MHz pixel clock. It counts clocks across each scan line and lines down each frame, and from those two counts it decodes an active-low composite sync, a blanking level and a text-window strobe. A downstream character fetch engine uses the text-window strobe, the line-start strobe and the two counters to address its video memory.

Two progressive standards are built in. The 50 Hz standard uses 416-clock lines and 312-line frames. The 60 Hz standard uses 414-clock lines and 262-line frames. Neither standard has a half line per frame. A select pin picks the standard for the next frame and is read on the last clock of each frame only. The first lines of every frame form the vertical interval. Each of these lines holds two half-line pulse slots, and each slot carries either a short equalizing pulse or a long broad pulse. The normal line sync is not used on these lines.

All pins are plain level or strobe signals with no handshake. The outputs are decoded directly from the counter registers, so they change one clock edge after the state that causes them.

Top module: `dual_std_sync_gen`

## Requirements
- R1: A synchronous active-high `rst` puts the block at line 0, clock 0 of a frame in the 50 Hz standard. `std_sel` = 0 selects 50 Hz and 1 selects 60 Hz.
- R2: `pix_cnt` steps by one every clock and wraps to 0 after 415 in the 50 Hz standard or after 414 - 1 = 413 in the 60 Hz standard. `line_start` is high exactly when `pix_cnt` is 0.
- R3: `line_cnt` steps by one at each line wrap and returns to 0 after line 311 (50 Hz) or after line 261 (60 Hz).
- R4: `std_sel` is sampled only on the final clock of a frame, and the sampled value governs the whole next frame starting at line 0, clock 0. Changes on `std_sel` at any other time have no effect on line length or frame length.
- R5: Outside the vertical interval, `csync_n` is low for clocks 0 to 30 of each line (31 clocks) and high for the rest of the line.
- R6: Lines 0 to 8 form the vertical interval. Half-line slot k = 2 × line + (1 if `pix_cnt` ≥ 207, else 0). Each slot starts at clock 0 or at clock 207 of its line. Slots 0–5 and 12–17 hold equalizing pulses, low for 15 clocks. Slots 6–11 hold broad pulses, low for 180 clocks.
- R7: `blank` is high for the whole of every vertical-interval line. On other lines it is high from clock 0 through the end of the back porch: clocks 0–67 in the 50 Hz standard and clocks 0–66 in the 60 Hz standard (the back porch there is one clock shorter).
- R8: `active` is high for 256 clocks per line. The window starts at clock 107 (50 Hz) or clock 106 (60 Hz), which is 39 clocks after blanking ends. It covers lines 64–255 (50 Hz) or lines 39–230 (60 Hz). The front porch is therefore 53 or 52 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 6.5 MHz pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| std_sel | input | 1 | Standard for the next frame: 0 = 50 Hz, 1 = 60 Hz |
| csync_n | output | 1 | Composite sync, active low |
| blank | output | 1 | Blanking level, high while the picture must be dark |
| line_start | output | 1 | High on clock 0 of every line |
| active | output | 1 | High inside the text window |
| line_cnt | output | 9 | Current line within the frame |
| pix_cnt | output | 9 | Current clock within the line |

## Verification
A scaled-down configuration is swept clock by clock over six whole frames, and every output is compared with a count-based model. The sequence of `std_sel` values runs 50→60, 60→60, 60→50, 50→50 and 50→60, so both standards meet at a frame boundary in each direction. Two frames receive a pulse on `std_sel` in the middle of the frame with the opposite value. These two frames separate sampling at the frame boundary from sampling at any other time. A second instance at the full default sizes is swept through its vertical interval and the first two normal lines. This pins down the 416-clock line, the 207-clock half-line slot and the 15/180-clock pulse widths.

// File: rtl/dssg_pkg.sv
package dssg_pkg;
  typedef enum logic {
    STD_50 = 1'b0,
    STD_60 = 1'b1
  } std_e;
endpackage

// File: rtl/dssg_timebase.sv
module dssg_timebase
  import dssg_pkg::*;
#(
  parameter int LINE_CLKS_50   = 416,
  parameter int LINE_CLKS_60   = 414,
  parameter int FRAME_LINES_50 = 312,
  parameter int FRAME_LINES_60 = 262,
  parameter int PW             = 9,
  parameter int LW             = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std_sel,
  output logic [PW-1:0] pix,
  output logic [LW-1:0] line,
  output std_e          mode,
  output logic          line_start
);
  localparam logic [PW-1:0] PIX_LAST_50  = PW'(LINE_CLKS_50 - 1);
  localparam logic [PW-1:0] PIX_LAST_60  = PW'(LINE_CLKS_60 - 1);
  localparam logic [LW-1:0] LINE_LAST_50 = LW'(FRAME_LINES_50 - 1);
  localparam logic [LW-1:0] LINE_LAST_60 = LW'(FRAME_LINES_60 - 1);

  logic line_end, frame_end;

  assign line_end   = (pix == ((mode == STD_60) ? PIX_LAST_60 : PIX_LAST_50));
  assign frame_end  = line_end && (line == ((mode == STD_60) ? LINE_LAST_60 : LINE_LAST_50));
  assign line_start = (pix == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      pix  <= '0;
      line <= '0;
      mode <= STD_50;
    end else if (line_end) begin
      pix <= '0;
      if (frame_end) begin
        line <= '0;
        mode <= std_e'(std_sel);  // sampled on the last clock of the frame only
      end else begin
        line <= line + LW'(1);
      end
    end else begin
      pix <= pix + PW'(1);
    end
  end

  // R2: clock counter steps and wraps
  a_r2_pix_step: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> pix == $past(pix) + PW'(1));
  a_r2_pix_wrap: assert property (@(posedge clk) disable iff (rst)
    line_end |=> pix == '0);
  // R3: line counter only moves at a line wrap
  a_r3_line_hold: assert property (@(posedge clk) disable iff (rst)
    !line_end |=> $stable(line));
  a_r3_line_wrap: assert property (@(posedge clk) disable iff (rst)
    frame_end |=> line == '0);
  // R4: the standard never changes inside a frame
  a_r4_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !frame_end |=> $stable(mode));
endmodule

// File: rtl/dssg_sync_shaper.sv
module dssg_sync_shaper #(
  parameter int HALF_CLKS    = 207,
  parameter int HSYNC_CLKS   = 31,
  parameter int EQ_CLKS      = 15,
  parameter int BROAD_CLKS   = 180,
  parameter int EQ_PULSES    = 6,
  parameter int BROAD_PULSES = 6,
  parameter int PW           = 9,
  parameter int LW           = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  output logic          in_vs,
  output logic          csync_n
);
  localparam int VS_HALVES = 2 * EQ_PULSES + BROAD_PULSES;
  localparam int VS_LINES  = VS_HALVES / 2;

  localparam logic [PW-1:0] HALF_P   = PW'(HALF_CLKS);
  localparam logic [PW-1:0] HSYNC_P  = PW'(HSYNC_CLKS);
  localparam logic [PW-1:0] EQ_P     = PW'(EQ_CLKS);
  localparam logic [PW-1:0] BROAD_P  = PW'(BROAD_CLKS);
  localparam logic [LW-1:0] VSL_P    = LW'(VS_LINES);
  localparam logic [LW:0]   BR_FIRST = (LW+1)'(EQ_PULSES);
  localparam logic [LW:0]   BR_END   = (LW+1)'(EQ_PULSES + BROAD_PULSES);

  logic          second_half;
  logic [LW:0]   slot;
  logic [PW-1:0] offs, width;
  logic          vs_low, hs_low;

  always_comb begin
    in_vs       = (line < VSL_P);
    second_half = (pix >= HALF_P);
    slot        = {line, second_half};          // 2*line + half
    offs        = second_half ? (pix - HALF_P) : pix;
    width       = ((slot >= BR_FIRST) && (slot < BR_END)) ? BROAD_P : EQ_P;
    vs_low      = (offs < width);
    hs_low      = (pix < HSYNC_P);
    csync_n     = in_vs ? !vs_low : !hs_low;
  end

  // R6: both half-line slots of a vertical-interval line open with sync low
  a_r6_slot0_low: assert property (@(posedge clk) disable iff (rst)
    (in_vs && pix == '0) |-> !csync_n);
  a_r6_slot1_low: assert property (@(posedge clk) disable iff (rst)
    (in_vs && pix == HALF_P) |-> !csync_n);
  // R5: normal sync is released right after its width
  a_r5_sync_release: assert property (@(posedge clk) disable iff (rst)
    (!in_vs && pix == HSYNC_P) |-> csync_n);
endmodule

// File: rtl/dssg_window.sv
module dssg_window
  import dssg_pkg::*;
#(
  parameter int HSYNC_CLKS   = 31,
  parameter int BACK_CLKS_50 = 37,
  parameter int TEXT_DLY     = 39,
  parameter int TEXT_CLKS    = 256,
  parameter int TOP_50       = 64,
  parameter int TOP_60       = 39,
  parameter int TEXT_LINES   = 192,
  parameter int PW           = 9,
  parameter int LW           = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pix,
  input  logic [LW-1:0] line,
  input  std_e          mode,
  input  logic          in_vs,
  output logic          blank,
  output logic          active
);
  // the 60 Hz back porch (and front porch) is one clock shorter
  localparam logic [PW-1:0] BEND_50 = PW'(HSYNC_CLKS + BACK_CLKS_50);
  localparam logic [PW-1:0] BEND_60 = PW'(HSYNC_CLKS + BACK_CLKS_50 - 1);
  localparam logic [PW-1:0] TS_50   = PW'(HSYNC_CLKS + BACK_CLKS_50 + TEXT_DLY);
  localparam logic [PW-1:0] TS_60   = PW'(HSYNC_CLKS + BACK_CLKS_50 - 1 + TEXT_DLY);
  localparam logic [PW-1:0] TE_50   = PW'(HSYNC_CLKS + BACK_CLKS_50 + TEXT_DLY + TEXT_CLKS);
  localparam logic [PW-1:0] TE_60   = PW'(HSYNC_CLKS + BACK_CLKS_50 - 1 + TEXT_DLY + TEXT_CLKS);
  localparam logic [LW-1:0] VT_50   = LW'(TOP_50);
  localparam logic [LW-1:0] VT_60   = LW'(TOP_60);
  localparam logic [LW-1:0] VB_50   = LW'(TOP_50 + TEXT_LINES);
  localparam logic [LW-1:0] VB_60   = LW'(TOP_60 + TEXT_LINES);

  logic          is60, h_win, v_win;
  logic [PW-1:0] bend, ts, te;
  logic [LW-1:0] vt, vb;

  always_comb begin
    is60   = (mode == STD_60);
    bend   = is60 ? BEND_60 : BEND_50;
    ts     = is60 ? TS_60 : TS_50;
    te     = is60 ? TE_60 : TE_50;
    vt     = is60 ? VT_60 : VT_50;
    vb     = is60 ? VB_60 : VB_50;
    blank  = in_vs || (pix < bend);
    h_win  = (pix >= ts) && (pix < te);
    v_win  = (line >= vt) && (line < vb);
    active = !in_vs && h_win && v_win;
  end

  // R8: the text window never overlaps blanking
  a_r8_active_unblanked: assert property (@(posedge clk) disable iff (rst)
    active |-> !blank);
endmodule

// File: rtl/dual_std_sync_gen.sv
module dual_std_sync_gen
  import dssg_pkg::*;
#(
  parameter int LINE_CLKS_50   = 416,
  parameter int LINE_CLKS_60   = 414,
  parameter int FRAME_LINES_50 = 312,
  parameter int FRAME_LINES_60 = 262,
  parameter int HALF_CLKS      = 207,
  parameter int HSYNC_CLKS     = 31,
  parameter int BACK_CLKS_50   = 37,
  parameter int TEXT_DLY       = 39,
  parameter int TEXT_CLKS      = 256,
  parameter int EQ_CLKS        = 15,
  parameter int BROAD_CLKS     = 180,
  parameter int EQ_PULSES      = 6,
  parameter int BROAD_PULSES   = 6,
  parameter int TOP_50         = 64,
  parameter int TOP_60         = 39,
  parameter int TEXT_LINES     = 192,
  localparam int PW = $clog2((LINE_CLKS_50 > LINE_CLKS_60) ? LINE_CLKS_50 : LINE_CLKS_60),
  localparam int LW = $clog2((FRAME_LINES_50 > FRAME_LINES_60) ? FRAME_LINES_50 : FRAME_LINES_60)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          std_sel,
  output logic          csync_n,
  output logic          blank,
  output logic          line_start,
  output logic          active,
  output logic [LW-1:0] line_cnt,
  output logic [PW-1:0] pix_cnt
);
  std_e mode;
  logic in_vs;

  dssg_timebase #(
    .LINE_CLKS_50(LINE_CLKS_50), .LINE_CLKS_60(LINE_CLKS_60),
    .FRAME_LINES_50(FRAME_LINES_50), .FRAME_LINES_60(FRAME_LINES_60),
    .PW(PW), .LW(LW)
  ) u_tb (
    .clk(clk), .rst(rst), .std_sel(std_sel),
    .pix(pix_cnt), .line(line_cnt), .mode(mode), .line_start(line_start)
  );

  dssg_sync_shaper #(
    .HALF_CLKS(HALF_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .EQ_CLKS(EQ_CLKS),
    .BROAD_CLKS(BROAD_CLKS), .EQ_PULSES(EQ_PULSES), .BROAD_PULSES(BROAD_PULSES),
    .PW(PW), .LW(LW)
  ) u_sync (
    .clk(clk), .rst(rst), .pix(pix_cnt), .line(line_cnt),
    .in_vs(in_vs), .csync_n(csync_n)
  );

  dssg_window #(
    .HSYNC_CLKS(HSYNC_CLKS), .BACK_CLKS_50(BACK_CLKS_50), .TEXT_DLY(TEXT_DLY),
    .TEXT_CLKS(TEXT_CLKS), .TOP_50(TOP_50), .TOP_60(TOP_60),
    .TEXT_LINES(TEXT_LINES), .PW(PW), .LW(LW)
  ) u_win (
    .clk(clk), .rst(rst), .pix(pix_cnt), .line(line_cnt), .mode(mode),
    .in_vs(in_vs), .blank(blank), .active(active)
  );

  // R7: sync is always inside blanking
  a_r7_sync_blanked: assert property (@(posedge clk) disable iff (rst)
    !csync_n |-> blank);
  // R2: line start strobe lasts one clock
  a_r2_start_single: assert property (@(posedge clk) disable iff (rst)
    line_start |=> !line_start);
endmodule

// File: tb/dual_std_sync_gen_tb_lane.sv
module dual_std_sync_gen_tb_lane #(
  parameter int LINE_CLKS_50   = 416,
  parameter int LINE_CLKS_60   = 414,
  parameter int FRAME_LINES_50 = 312,
  parameter int FRAME_LINES_60 = 262,
  parameter int HALF_CLKS      = 207,
  parameter int HSYNC_CLKS     = 31,
  parameter int BACK_CLKS_50   = 37,
  parameter int TEXT_DLY       = 39,
  parameter int TEXT_CLKS      = 256,
  parameter int EQ_CLKS        = 15,
  parameter int BROAD_CLKS     = 180,
  parameter int EQ_PULSES      = 6,
  parameter int BROAD_PULSES   = 6,
  parameter int TOP_50         = 64,
  parameter int TOP_60         = 39,
  parameter int TEXT_LINES     = 192,
  parameter int NFRAMES        = 1,
  parameter int MAX_LINES      = 11,
  parameter int DO_SWITCH      = 0
) (
  input  logic clk,
  input  logic rst,
  output logic done,
  output int   n_chk,
  output int   n_err
);
  localparam int PW = $clog2((LINE_CLKS_50 > LINE_CLKS_60) ? LINE_CLKS_50 : LINE_CLKS_60);
  localparam int LW = $clog2((FRAME_LINES_50 > FRAME_LINES_60) ? FRAME_LINES_50 : FRAME_LINES_60);
  localparam int VSL = (2 * EQ_PULSES + BROAD_PULSES) / 2;
  // next-frame standard per frame index, and frames with an opposite mid-frame pulse
  localparam logic [7:0] BASE   = 8'b0001_0011;
  localparam logic [7:0] GLITCH = 8'b0000_1010;

  logic          sel;
  logic          csync_n, blank, line_start, active;
  logic [LW-1:0] line_cnt;
  logic [PW-1:0] pix_cnt;

  dual_std_sync_gen #(
    .LINE_CLKS_50(LINE_CLKS_50), .LINE_CLKS_60(LINE_CLKS_60),
    .FRAME_LINES_50(FRAME_LINES_50), .FRAME_LINES_60(FRAME_LINES_60),
    .HALF_CLKS(HALF_CLKS), .HSYNC_CLKS(HSYNC_CLKS), .BACK_CLKS_50(BACK_CLKS_50),
    .TEXT_DLY(TEXT_DLY), .TEXT_CLKS(TEXT_CLKS), .EQ_CLKS(EQ_CLKS),
    .BROAD_CLKS(BROAD_CLKS), .EQ_PULSES(EQ_PULSES), .BROAD_PULSES(BROAD_PULSES),
    .TOP_50(TOP_50), .TOP_60(TOP_60), .TEXT_LINES(TEXT_LINES)
  ) dut_i (
    .clk(clk), .rst(rst), .std_sel(sel), .csync_n(csync_n), .blank(blank),
    .line_start(line_start), .active(active), .line_cnt(line_cnt), .pix_cnt(pix_cnt)
  );

  int m_line, m_pix, m_mode, frames, lines;

  initial begin
    n_chk = 0; n_err = 0; sel = 1'b0;
    m_line = 0; m_pix = 0; m_mode = 0; frames = 0; lines = 0;
  end

  assign done = (frames >= NFRAMES) || (lines >= MAX_LINES);

  // reference count model, advanced from the requirements
  always @(posedge clk) begin
    if (rst) begin
      m_line = 0; m_pix = 0; m_mode = 0; frames = 0; lines = 0;
    end else begin
      if (m_pix == ((m_mode != 0) ? LINE_CLKS_60 : LINE_CLKS_50) - 1) begin
        m_pix = 0;
        lines = lines + 1;
        if (m_line == ((m_mode != 0) ? FRAME_LINES_60 : FRAME_LINES_50) - 1) begin
          m_line = 0;
          m_mode = sel ? 1 : 0;
          frames = frames + 1;
        end else begin
          m_line = m_line + 1;
        end
      end else begin
        m_pix = m_pix + 1;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input int exp);
    n_chk = n_chk + 1;
    if (act !== 32'(exp)) begin
      n_err = n_err + 1;
      $display("FAIL %s %s line %0d clk %0d: actual %0d expected %0d",
               tag, what, m_line, m_pix, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      sel = 1'b0;
    end else if (!done) begin
      int len, second, off, slot, w, back, ts, top, e_cs, e_bl, e_act;
      len    = (m_mode != 0) ? LINE_CLKS_60 : LINE_CLKS_50;
      second = (m_pix >= HALF_CLKS) ? 1 : 0;
      off    = (second != 0) ? m_pix - HALF_CLKS : m_pix;
      slot   = 2 * m_line + second;
      w      = (slot >= EQ_PULSES && slot < EQ_PULSES + BROAD_PULSES) ? BROAD_CLKS : EQ_CLKS;
      back   = BACK_CLKS_50 - m_mode;
      ts     = HSYNC_CLKS + back + TEXT_DLY;
      top    = (m_mode != 0) ? TOP_60 : TOP_50;
      if (m_line < VSL) e_cs = (off < w) ? 0 : 1;
      else              e_cs = (m_pix < HSYNC_CLKS) ? 0 : 1;
      e_bl   = (m_line < VSL || m_pix < HSYNC_CLKS + back) ? 1 : 0;
      e_act  = (m_line >= VSL && m_line >= top && m_line < top + TEXT_LINES &&
                m_pix >= ts && m_pix < ts + TEXT_CLKS) ? 1 : 0;

      if (frames == 0 && lines == 0 && m_pix == 0) begin
        chk("R1", "line after reset", 32'(line_cnt), 0);
        chk("R1", "clk after reset", 32'(pix_cnt), 0);
      end
      chk("R2", "pix_cnt", 32'(pix_cnt), m_pix);
      chk("R2", "line_start", 32'(line_start), (m_pix == 0) ? 1 : 0);
      chk("R3", "line_cnt", 32'(line_cnt), m_line);
      if (m_line == 0 && m_pix == len - 1)
        chk("R4", "line length of frame standard", 32'(pix_cnt), len - 1);
      if (m_line < VSL) chk("R6", "csync_n vertical", 32'(csync_n), e_cs);
      else              chk("R5", "csync_n line", 32'(csync_n), e_cs);
      chk("R7", "blank", 32'(blank), e_bl);
      chk("R8", "active", 32'(active), e_act);

      sel = (DO_SWITCH != 0) &&
            (BASE[frames[2:0]] ^ (GLITCH[frames[2:0]] && m_line >= 2 && m_line <= 5));
    end
  end
endmodule

// File: tb/dual_std_sync_gen_tb_top.sv
module dual_std_sync_gen_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic done_s, done_d;
  int   chk_s, err_s, chk_d, err_d;
  int   wd_err = 0;

  always #5 clk = ~clk;

  // scaled configuration, swept over six frames with standard changes
  dual_std_sync_gen_tb_lane #(
    .LINE_CLKS_50(40), .LINE_CLKS_60(38), .FRAME_LINES_50(20), .FRAME_LINES_60(18),
    .HALF_CLKS(19), .HSYNC_CLKS(3), .BACK_CLKS_50(4), .TEXT_DLY(3), .TEXT_CLKS(16),
    .EQ_CLKS(2), .BROAD_CLKS(15), .EQ_PULSES(2), .BROAD_PULSES(2),
    .TOP_50(6), .TOP_60(5), .TEXT_LINES(8),
    .NFRAMES(6), .MAX_LINES(1000), .DO_SWITCH(1)
  ) small_lane (
    .clk(clk), .rst(rst), .done(done_s), .n_chk(chk_s), .n_err(err_s)
  );

  // full default sizes, vertical interval plus two normal lines
  dual_std_sync_gen_tb_lane #(
    .NFRAMES(1), .MAX_LINES(11), .DO_SWITCH(0)
  ) full_lane (
    .clk(clk), .rst(rst), .done(done_d), .n_chk(chk_d), .n_err(err_d)
  );

  initial begin
    int cyc;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    cyc = 0;
    while (!(done_s && done_d) && cyc < 150000) begin
      @(posedge clk);
      cyc = cyc + 1;
    end
    if (!(done_s && done_d)) begin
      wd_err = 1;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    end
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors",
             chk_s + chk_d + wd_err, err_s + err_d + wd_err);
    $finish;
  end
endmodule